// File: doc/BRIEF.md
# Interrupt Request Controller

This block sits beside a small CPU core and gathers interrupt request flags from eight event sources: two external request lines, overflow events from three timers, a falling edge on the third timer's external pin, and receive-done and transmit-done events from a serial port. Each event sets a flag. The flags are grouped into six sources. Each source has its own enable bit, and one global enable bit gates all six.

At each instruction-boundary strobe from the CPU, the block checks the enabled pending sources and picks one in a fixed order. It then gives the CPU a one-cycle take pulse together with that source's vector address. An in-service flag is set when a request is taken. While it is set, no further request is taken. A return strobe from the CPU clears it.

The two external flags and the first two timer flags clear themselves when their request is taken. The serial flags and the third timer's flags stay set until software clears them, because each pair shares one vector. Software can set or clear any flag, and any enable bit, through a bit-masked register write port.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `enable_o`, `flags_o`, `take_o` and `in_service_o` are all 0. No request is taken until software sets enable bits.
- R2: While global enable (`enable_o[7]`) is 0, no request is taken, whatever the per-source enables are.
- R3: Sources in service order are: external 0 (flag bit 0), timer 0 (bit 1), external 1 (bit 2), timer 1 (bit 3), serial (bit 4 receive OR bit 5 transmit), timer 2 (bit 6 overflow OR bit 7 pin edge). Their per-source enables are `enable_o[0..5]` in that order. The vector for source k is 0x0003 + 8*k.
- R4: Taking external 0, timer 0, external 1 or timer 1 clears that source's flag in the same clock edge.
- R5: Taking the serial or timer 2 source leaves flag bits 4 to 7 unchanged.
- R6: Flag bit 7 is set only by a 1-to-0 change on `t2_pin_i`. A steady low or a rising change does not set it. Flag bit 6 is set by `tmr2_ovf_i`.
- R7: A write with `reg_sel_i`=1 loads `reg_wdata_i` into the flag bits whose `reg_mask_i` bit is 1 and leaves the other flag bits unchanged. A hardware set in the same cycle overrides a software clear.
- R8: A take sets `in_service_o`. While it is set, boundary strobes produce no take. `reti_i` clears it.
- R9: While `tmr0_split_i` is 1, `tmr0_hi_ovf_i` does not set flag bit 1. While it is 0, it does.
- R10: A take happens only on a cycle where `boundary_i` is 1. `take_o` and `vector_o` become valid in the next cycle, and `take_o` lasts one cycle.
- R11: A write with `reg_sel_i`=0 updates only the enable bits selected by `reg_mask_i`. Bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext0_i | input | 1 | External request 0 event |
| ext1_i | input | 1 | External request 1 event |
| tmr0_ovf_i | input | 1 | Timer 0 overflow event |
| tmr0_hi_ovf_i | input | 1 | Timer 0 upper-half overflow event |
| tmr0_split_i | input | 1 | Timer 0 split mode; masks the upper-half path |
| tmr1_ovf_i | input | 1 | Timer 1 overflow event |
| ser_rx_done_i | input | 1 | Serial byte received |
| ser_tx_done_i | input | 1 | Serial byte sent |
| tmr2_ovf_i | input | 1 | Timer 2 rollover |
| t2_pin_i | input | 1 | Timer 2 external pin level |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: enable register, 1: flag register |
| reg_mask_i | input | 8 | Per-bit write select |
| reg_wdata_i | input | 8 | Write data |
| boundary_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| enable_o | output | 8 | Enable register |
| flags_o | output | 8 | Flag register |
| take_o | output | 1 | Take-interrupt pulse |
| vector_o | output | 16 | Vector address of the taken source |
| in_service_o | output | 1 | In-service flag |

## Verification
The bench sets every flag at once and walks the full service order with return strobes. A wrong priority chain would show up as vectors out of order. The bench also takes the serial source twice without a software clear; a design that auto-cleared the shared flags would skip the second take. It fires a hardware overflow together with a software clear of the same bit, holds the timer 2 pin low and raises it, and pulses the upper-half overflow in split mode. Each of these catches a wrong set/clear precedence, a level-triggered pin flag, or an unmasked split path. Boundaries with the global enable off, and boundaries while a request is in service, catch any take that leaks through those gates.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 6;
  localparam int NUM_FLAG = 8;
  localparam int EN_W     = 8;
  localparam int EA_BIT   = 7;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_FLAGS  = 1'b1
  } reg_sel_e;

  function automatic logic [15:0] vec_addr(int idx, int base, int stride);
    return 16'(base + idx * stride);
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int NF = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] hw_set_i,
  input  logic          sw_we_i,
  input  logic [NF-1:0] sw_mask_i,
  input  logic [NF-1:0] sw_data_i,
  input  logic [NF-1:0] ack_clr_i,
  output logic [NF-1:0] flags_o
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        flags_o[i] <= 1'b0;
      else if (hw_set_i[i])               flags_o[i] <= 1'b1;
      else if (sw_we_i && sw_mask_i[i])   flags_o[i] <= sw_data_i[i];
      else if (ack_clr_i[i])              flags_o[i] <= 1'b0;
    end

    a_r7_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_set_i[i] |=> flags_o[i]);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NS     = 6,
  parameter int AW     = 16,
  parameter int BASE   = 3,
  parameter int STRIDE = 8
) (
  input  logic [NS-1:0] req_i,
  output logic          valid_o,
  output logic [NS-1:0] grant_o,
  output logic [AW-1:0] vec_o
);
  import irq_pkg::*;

  logic [NS:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NS; i++) begin : g_prio
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign valid_o = seen[NS];

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NS; i++)
      if (grant_o[i]) vec_o = AW'(vec_addr(i, BASE, STRIDE));
  end

  always_comb begin
    a_r3_single_grant: assert ($onehot0(grant_o));
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext0_i,
  input  logic              ext1_i,
  input  logic              tmr0_ovf_i,
  input  logic              tmr0_hi_ovf_i,
  input  logic              tmr0_split_i,
  input  logic              tmr1_ovf_i,
  input  logic              ser_rx_done_i,
  input  logic              ser_tx_done_i,
  input  logic              tmr2_ovf_i,
  input  logic              t2_pin_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [7:0]        reg_mask_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic              boundary_i,
  input  logic              reti_i,
  output logic [7:0]        enable_o,
  output logic [7:0]        flags_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] vector_o,
  output logic              in_service_o
);
  import irq_pkg::*;

  localparam logic [EN_W-1:0] EN_IMPL = EN_W'((1 << EA_BIT) | ((1 << NUM_SRC) - 1));
  localparam int              AUTO_CLR_SRC = 4;

  logic [EN_W-1:0]     en_q;
  logic [NUM_FLAG-1:0] flags_q, hw_set, ack_clr;
  logic [NUM_SRC-1:0]  req, pend, grant;
  logic [ADDR_W-1:0]   arb_vec, vec_q;
  logic                arb_valid, take_now, take_q, in_svc_q, t2_pin_q, t2_fall;
  logic                we_en, we_flag;

  assign we_en   = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_ENABLE);
  assign we_flag = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_FLAGS);

  // enable register, unimplemented bits held at 0
  for (genvar i = 0; i < EN_W; i++) begin : g_en
    if (EN_IMPL[i]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       en_q[i] <= 1'b0;
        else if (we_en && reg_mask_i[i])   en_q[i] <= reg_wdata_i[i];
      end
    end else begin : g_tie
      assign en_q[i] = 1'b0;
    end
  end

  // timer 2 pin falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t2_pin_q <= 1'b0;
    else         t2_pin_q <= t2_pin_i;
  end
  assign t2_fall = t2_pin_q & ~t2_pin_i;

  assign hw_set = {t2_fall, tmr2_ovf_i, ser_tx_done_i, ser_rx_done_i,
                   tmr1_ovf_i, ext1_i,
                   tmr0_ovf_i | (tmr0_hi_ovf_i & ~tmr0_split_i), ext0_i};

  irq_flags #(.NF(NUM_FLAG)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_set_i  (hw_set),
    .sw_we_i   (we_flag),
    .sw_mask_i (reg_mask_i),
    .sw_data_i (reg_wdata_i),
    .ack_clr_i (ack_clr),
    .flags_o   (flags_q)
  );

  // flags -> sources: first four one-to-one, last two paired
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s < AUTO_CLR_SRC) begin : g_single
      assign req[s] = flags_q[s];
    end else begin : g_pair
      assign req[s] = flags_q[2*s-AUTO_CLR_SRC] | flags_q[2*s-AUTO_CLR_SRC+1];
    end
  end

  assign pend = req & en_q[NUM_SRC-1:0] & {NUM_SRC{en_q[EA_BIT]}};

  irq_arbiter #(
    .NS(NUM_SRC), .AW(ADDR_W), .BASE(VEC_BASE), .STRIDE(VEC_STRIDE)
  ) u_arb (
    .req_i   (pend),
    .valid_o (arb_valid),
    .grant_o (grant),
    .vec_o   (arb_vec)
  );

  assign take_now = boundary_i & ~in_svc_q & arb_valid;
  assign ack_clr  = NUM_FLAG'(grant[AUTO_CLR_SRC-1:0]) & {NUM_FLAG{take_now}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q   <= 1'b0;
      vec_q    <= '0;
      in_svc_q <= 1'b0;
    end else begin
      take_q <= take_now;
      if (take_now) vec_q <= arb_vec;
      if (take_now)    in_svc_q <= 1'b1;
      else if (reti_i) in_svc_q <= 1'b0;
    end
  end

  assign enable_o     = en_q;
  assign flags_o      = flags_q;
  assign take_o       = take_q;
  assign vector_o     = vec_q;
  assign in_service_o = in_svc_q;

  a_r2_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(en_q[EA_BIT]));
  a_r8_no_nesting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !$past(in_svc_q));
  a_r8_in_service_on_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> in_service_o);
  a_r10_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  a_r4_tmr0_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(grant[1]) && !$past(hw_set[1]) && !$past(we_flag && reg_mask_i[1]))
      |-> !flags_q[1]);
  a_r5_serial_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && $past(flags_q[4]) && !$past(we_flag && reg_mask_i[4])) |-> flags_q[4]);
endmodule

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext0 = 0, ext1 = 0, t0 = 0, t0hi = 0, split = 0, t1 = 0;
  logic rx = 0, tx = 0, t2 = 0, t2pin = 0;
  logic we = 0, sel = 0, boundary = 0, reti = 0;
  logic [7:0] mask = 0, wdata = 0;
  logic [7:0] enable, flags;
  logic take, in_svc;
  logic [15:0] vector;

  int checks = 0, errors = 0, take_cnt = 0;
  logic [15:0] exp_q[$];
  logic prev_take = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ext0_i(ext0), .ext1_i(ext1),
    .tmr0_ovf_i(t0), .tmr0_hi_ovf_i(t0hi), .tmr0_split_i(split),
    .tmr1_ovf_i(t1), .ser_rx_done_i(rx), .ser_tx_done_i(tx),
    .tmr2_ovf_i(t2), .t2_pin_i(t2pin), .reg_we_i(we), .reg_sel_i(sel),
    .reg_mask_i(mask), .reg_wdata_i(wdata), .boundary_i(boundary),
    .reti_i(reti), .enable_o(enable), .flags_o(flags), .take_o(take),
    .vector_o(vector), .in_service_o(in_svc)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected vectors as takes appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (take) begin
        take_cnt++;
        if (exp_q.size() == 0) check(0, "R2/R8 unexpected take", 32'(vector), 32'hffff);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(vector == e, "R3 vector", 32'(vector), 32'(e));
        end
        if (prev_take) check(0, "R10 pulse width", 2, 1);
      end
      prev_take = take;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic s, logic [7:0] m, logic [7:0] d);
    @(negedge clk); we = 1; sel = s; mask = m; wdata = d;
    @(negedge clk); we = 0; mask = 0;
  endtask

  task automatic strobe(logic [15:0] expv, bit expect_take);
    if (expect_take) exp_q.push_back(expv);
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    cyc(1);
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
  endtask

  // one-cycle hardware event: bit order = flag layout
  task automatic hw(logic [7:0] ev);
    @(negedge clk);
    ext0 = ev[0]; t0 = ev[1]; ext1 = ev[2]; t1 = ev[3];
    rx = ev[4]; tx = ev[5]; t2 = ev[6];
    @(negedge clk);
    {ext0, t0, ext1, t1, rx, tx, t2} = '0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int tc;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    check(enable == 0, "R1 enable", enable, 0);
    check(flags == 0, "R1 flags", flags, 0);
    check(take == 0 && in_svc == 0, "R1 take/in_service", {take, in_svc}, 0);

    // R1: flags pending, nothing enabled
    hw(8'b0000_1001);
    check(flags == 8'h09, "R1 flags set", flags, 8'h09);
    tc = take_cnt;
    strobe(0, 0);
    check(take_cnt == tc, "R1 no take when disabled", take_cnt, tc);

    // R2: sources enabled, global off
    wr(0, 8'h3F, 8'hFF);
    check(enable == 8'h3F, "R11 source enables", enable, 8'h3F);
    strobe(0, 0);
    check(take_cnt == tc, "R2 global gate", take_cnt, tc);

    // R11: single-bit write, bit 6 stays 0
    wr(0, 8'hC0, 8'hC0);
    check(enable == 8'hBF, "R11 per-bit write", enable, 8'hBF);

    // R3/R4/R8: ext0 first, auto-cleared; in-service blocks
    strobe(16'h0003, 1);
    check(flags == 8'h08, "R4 ext0 cleared", flags, 8'h08);
    check(in_svc == 1, "R8 in service set", in_svc, 1);
    tc = take_cnt;
    strobe(0, 0);
    check(take_cnt == tc, "R8 blocked while in service", take_cnt, tc);
    do_reti();
    check(in_svc == 0, "R8 reti clears", in_svc, 0);
    strobe(16'h001B, 1);
    check(flags == 8'h00, "R4 tmr1 cleared", flags, 0);
    do_reti();

    // R5: serial flags sticky, second take without clear
    hw(8'b0001_0000);
    strobe(16'h0023, 1);
    check(flags == 8'h10, "R5 rx sticky", flags, 8'h10);
    do_reti();
    strobe(16'h0023, 1);
    do_reti();
    wr(1, 8'h10, 8'h00);
    check(flags == 8'h00, "R7 sw clear", flags, 0);

    // R6: pin edges
    wr(0, 8'h80, 8'h00);
    @(negedge clk); t2pin = 1;
    cyc(2);
    check(flags == 8'h00, "R6 rising edge ignored", flags, 0);
    @(negedge clk); t2pin = 0;
    cyc(1);
    check(flags == 8'h80, "R6 falling edge", flags, 8'h80);
    wr(1, 8'h80, 8'h00);
    cyc(3);
    check(flags == 8'h00, "R6 steady low no set", flags, 0);
    hw(8'b0100_0000);
    check(flags == 8'h40, "R6 tmr2 rollover", flags, 8'h40);
    wr(1, 8'hFF, 8'h00);

    // R3: full order from software-set flags
    wr(1, 8'hFF, 8'hFF);
    check(flags == 8'hFF, "R7 sw set all", flags, 8'hFF);
    wr(0, 8'h80, 8'h80);
    strobe(16'h0003, 1); do_reti();
    strobe(16'h000B, 1); do_reti();
    strobe(16'h0013, 1); do_reti();
    strobe(16'h001B, 1); do_reti();
    strobe(16'h0023, 1); do_reti();
    check(flags == 8'hF0, "R5 shared flags kept", flags, 8'hF0);
    wr(0, 8'h10, 8'h00);
    strobe(16'h002B, 1); do_reti();
    check(flags == 8'hF0, "R5 tmr2 flags kept", flags, 8'hF0);
    wr(1, 8'hFF, 8'h00);

    // R9: split mode masks upper-half path
    @(negedge clk); split = 1; t0hi = 1;
    @(negedge clk); t0hi = 0;
    check(flags[1] == 0, "R9 split masks", flags[1], 0);
    @(negedge clk); split = 0; t0hi = 1;
    @(negedge clk); t0hi = 0;
    check(flags[1] == 1, "R9 normal path", flags[1], 1);

    // R7: hw set beats sw clear
    wr(1, 8'h02, 8'h00);
    @(negedge clk); we = 1; sel = 1; mask = 8'h02; wdata = 8'h00; t0 = 1;
    @(negedge clk); we = 0; mask = 0; t0 = 0;
    check(flags[1] == 1, "R7 hw wins", flags[1], 1);

    // R10: no take without boundary
    tc = take_cnt;
    cyc(4);
    check(take_cnt == tc, "R10 boundary required", take_cnt, tc);
    strobe(16'h000B, 1);
    check(take == 0, "R10 take one cycle", take, 0);
    do_reti();

    // R2: global off again with pending
    hw(8'b0000_0100);
    wr(0, 8'h80, 8'h00);
    tc = take_cnt;
    strobe(0, 0);
    check(take_cnt == tc, "R2 global off blocks", take_cnt, tc);

    cyc(2);
    check(exp_q.size() == 0, "R3 all expected takes seen", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule